// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the software-facing half of an SPI master controller. It decodes word-aligned 32-bit register reads and writes, queues transmit words in a TX FIFO, and hands received words to software from an RX FIFO. It also drives active-low chip-select lines and issues a one-cycle start pulse to a separate serial transfer engine. The engine pops the TX FIFO, pushes the RX FIFO and reports completion. Writing the control register with its enable bit clear is a soft reset.

A transfer is started in one of two ways. With start-mode-control (SMC) set, a start fires as soon as a word is queued, or when SMC is newly set while words are waiting. With SMC clear, a start fires when software newly sets the exchange bit (XCH). Either way the channel must be configured as master. The start state machine has three named states. LS_IDLE goes to LS_LAUNCH on an accepted start request. LS_LAUNCH always goes to LS_BUSY after one cycle, and `xfer_start` is high during that cycle. LS_BUSY returns to LS_IDLE on `eng_done`. A soft reset forces LS_IDLE from any state. While the machine is in LS_LAUNCH or LS_BUSY, the XCH bit reads back as 1.

Register indices are byte offset divided by four: 0 control, 1 config, 2 TX data, 3 RX data, 4 interrupt enable, 5 status, 6 DMA, 7 period, 8 test, 9 message data. Control fields: enable bit 0, XCH bit 2, SMC bit 3, channel-mode bits [7:4] (one bit per channel), channel select bits [19:18], burst length minus one bits [31:20]. Status bits: 0 TX empty, 1 TX full, 2 RX not empty, 3 RX full, 4 RX overflow, 5 transfer complete.

Top module: `spi_regfront`

## Requirements
- R1: An access is decoded only when the address is word aligned and the index (byte address shifted right by two) is below 10. Any other access reads zero and its write changes nothing.
- R2: A TX data write is dropped when the enable bit is clear or the TX FIFO holds FIFO_DEPTH words. Accepted words reach the engine in write order.
- R3: An RX data read returns 0 while disabled, without popping. When enabled it returns 0xDEADBEEF if the RX FIFO is empty, and otherwise pops and returns the oldest word.
- R4: TX data and message data read as zero. Writes to RX data and to message data have no visible effect.
- R5: A control write with bit 0 clear zeroes every register, empties both FIFOs, returns the start machine to LS_IDLE and drives every chip select high.
- R6: A control write with enable set and with the channel-mode bit of the newly written channel select set drives that chip select low and all others high. Other control writes leave the chip selects unchanged.
- R7: With master mode and SMC set, an accepted TX data write requests a start.
- R8: A control write that enables a master channel requests a start in two cases. The first is when it newly sets SMC while the TX FIFO is not empty. The second is when it newly sets XCH with SMC clear in the written value. No other control write requests one.
- R9: An accepted request raises `xfer_start` for exactly the next cycle. XCH reads 1 from that cycle until `eng_done`, which clears XCH and sets the transfer-complete status bit.
- R10: Status bits 0 to 3 track the FIFO levels. An engine push into a full RX FIFO is dropped and sets bit 4. Writing ones to bits 4 and 5 clears them, and writing ones to other bits has no effect.
- R11: `irq` is high exactly when some status bit and the same interrupt-enable bit are both set.
- R12: Config, interrupt enable, DMA, period and test registers read back the value last written.
- R13: `burst_len` equals control bits [31:20] plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq | output | 1 | Interrupt level |
| cs_n | output | NCS | Active-low chip selects |
| xfer_start | output | 1 | One-cycle start pulse to the engine |
| burst_len | output | 13 | Burst length in bits |
| eng_tx_pop | input | 1 | Engine takes the TX head word |
| eng_tx_data | output | 32 | TX FIFO head word |
| eng_tx_empty | output | 1 | TX FIFO empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_done | input | 1 | Engine finished the transfer |

## Verification
The bench builds the block with ADDR_W = 6 and FIFO_DEPTH = 4, keeping NCS = 4. The 6-bit address lets the bench sweep every byte address, so every misaligned offset and every unused index from 10 to 15 is visited. The four-entry FIFOs make the full, drop and overflow corners reachable in a handful of writes. With four channels, all sixteen channel-mode patterns can be crossed with all four channel selects.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;
    localparam int unsigned NREG     = 10;
    localparam int unsigned IDX_CTRL = 0;
    localparam int unsigned IDX_CFG  = 1;
    localparam int unsigned IDX_TX   = 2;
    localparam int unsigned IDX_RX   = 3;
    localparam int unsigned IDX_IEN  = 4;
    localparam int unsigned IDX_STAT = 5;
    localparam int unsigned IDX_DMA  = 6;
    localparam int unsigned IDX_PER  = 7;
    localparam int unsigned IDX_TST  = 8;
    localparam int unsigned IDX_MSG  = 9;

    localparam int unsigned CTL_EN      = 0;
    localparam int unsigned CTL_XCH     = 2;
    localparam int unsigned CTL_SMC     = 3;
    localparam int unsigned CTL_MODE_LO = 4;
    localparam int unsigned CTL_SEL_LO  = 18;
    localparam int unsigned CTL_BL_LO   = 20;

    localparam int unsigned ST_W  = 6;
    localparam int unsigned ST_TE = 0;
    localparam int unsigned ST_TF = 1;
    localparam int unsigned ST_RR = 2;
    localparam int unsigned ST_RF = 3;
    localparam int unsigned ST_RO = 4;
    localparam int unsigned ST_TC = 5;

    localparam logic [31:0] RX_EMPTY_WORD = 32'hDEAD_BEEF;

    typedef enum logic [1:0] {
        LS_IDLE   = 2'd0,
        LS_LAUNCH = 2'd1,
        LS_BUSY   = 2'd2
    } launch_state_e;
endpackage

// File: rtl/spi_regfront_fifo.sv
module spi_regfront_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= wdata;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !flush && !do_pop) |=> full); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !flush && !push) |=> empty); // R3
endmodule

// File: rtl/spi_regfront_launch.sv
module spi_regfront_launch
    import spi_regfront_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic req,
    input  logic done,
    output logic ready,
    output logic active,
    output logic waiting,
    output logic start
);
    launch_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE:   if (req)  state_d = LS_LAUNCH;
            LS_LAUNCH:           state_d = LS_BUSY;
            LS_BUSY:   if (done) state_d = LS_IDLE;
            default:             state_d = LS_IDLE;
        endcase
        if (flush) state_d = LS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ready   = 1'b0;
        active  = 1'b0;
        waiting = 1'b0;
        start   = 1'b0;
        unique case (state_q)
            LS_IDLE:   ready = 1'b1;
            LS_LAUNCH: begin active = 1'b1; start = 1'b1; end
            LS_BUSY:   begin active = 1'b1; waiting = 1'b1; end
            default:   ready = 1'b1;
        endcase
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start); // R9
endmodule

// File: rtl/spi_regfront_csdrv.sv
module spi_regfront_csdrv #(
    parameter int NCS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   update,
    input  logic [$clog2(NCS)-1:0] sel,
    output logic [NCS-1:0]         cs_n
);
    for (genvar i = 0; i < NCS; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cs_n[i] <= 1'b1;
            else if (clear)  cs_n[i] <= 1'b1;
            else if (update) cs_n[i] <= (sel != $clog2(NCS)'(i));
        end
    end

    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1); // R6
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
    import spi_regfront_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int FIFO_DEPTH = 64,
    parameter int NCS        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic [NCS-1:0]    cs_n,
    output logic              xfer_start,
    output logic [12:0]       burst_len,
    input  logic              eng_tx_pop,
    output logic [31:0]       eng_tx_data,
    output logic              eng_tx_empty,
    input  logic              eng_rx_push,
    input  logic [31:0]       eng_rx_data,
    input  logic              eng_done
);
    localparam int SELW = $clog2(NCS);

    logic [31:0] ctrl_q, cfg_q, ien_q, dma_q, per_q, tst_q;
    logic        ro_q, tc_q;

    // decode
    int unsigned idx;
    logic        hit, wr_ev, rd_ev;
    assign idx   = 32'(bus_addr[ADDR_W-1:2]);
    assign hit   = bus_sel && (bus_addr[1:0] == 2'b00) && (idx < NREG);
    assign wr_ev = hit && bus_wr;
    assign rd_ev = hit && !bus_wr;

    logic wr_ctrl, wr_tx, wr_stat, rd_rx;
    assign wr_ctrl = wr_ev && (idx == IDX_CTRL);
    assign wr_tx   = wr_ev && (idx == IDX_TX);
    assign wr_stat = wr_ev && (idx == IDX_STAT);
    assign rd_rx   = rd_ev && (idx == IDX_RX);

    // current and written control views
    logic            en, master, new_master;
    logic [SELW-1:0] sel_q, sel_new;
    logic [NCS-1:0]  mode_q, mode_new;
    assign en         = ctrl_q[CTL_EN];
    assign sel_q      = ctrl_q[CTL_SEL_LO +: SELW];
    assign mode_q     = ctrl_q[CTL_MODE_LO +: NCS];
    assign master     = mode_q[sel_q];
    assign sel_new    = bus_wdata[CTL_SEL_LO +: SELW];
    assign mode_new   = bus_wdata[CTL_MODE_LO +: NCS];
    assign new_master = mode_new[sel_new];

    logic soft_rst;
    assign soft_rst = wr_ctrl && !bus_wdata[CTL_EN];

    // FIFOs
    logic        tx_empty, tx_full, rx_empty, rx_full;
    logic        tx_push, tx_pop, rx_push, rx_pop;
    logic [31:0] rx_head;
    assign tx_push = wr_tx && en && !tx_full;
    assign tx_pop  = eng_tx_pop && !tx_empty;
    assign rx_push = eng_rx_push && !rx_full;
    assign rx_pop  = rd_rx && en && !rx_empty;

    spi_regfront_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .push(tx_push), .wdata(bus_wdata), .pop(tx_pop),
        .rdata(eng_tx_data), .empty(tx_empty), .full(tx_full)
    );

    spi_regfront_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .push(rx_push), .wdata(eng_rx_data), .pop(rx_pop),
        .rdata(rx_head), .empty(rx_empty), .full(rx_full)
    );

    assign eng_tx_empty = tx_empty;

    // start requests
    logic req_tx, req_ctrl, launch_req;
    logic lz_ready, lz_active, lz_waiting, done_evt;
    assign req_tx = tx_push && master && ctrl_q[CTL_SMC];
    assign req_ctrl = wr_ctrl && bus_wdata[CTL_EN] && new_master &&
        ((bus_wdata[CTL_SMC] && !ctrl_q[CTL_SMC] && !tx_empty) ||
         (bus_wdata[CTL_XCH] && !ctrl_q[CTL_XCH] && !bus_wdata[CTL_SMC]));
    assign launch_req = req_tx || req_ctrl;
    assign done_evt   = eng_done && lz_waiting;

    spi_regfront_launch u_launch (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .req(launch_req), .done(eng_done),
        .ready(lz_ready), .active(lz_active), .waiting(lz_waiting),
        .start(xfer_start)
    );

    spi_regfront_csdrv #(.NCS(NCS)) u_cs (
        .clk(clk), .rst_n(rst_n), .clear(soft_rst),
        .update(wr_ctrl && bus_wdata[CTL_EN] && new_master),
        .sel(sel_new), .cs_n(cs_n)
    );

    // register state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0; cfg_q <= '0; ien_q <= '0;
            dma_q  <= '0; per_q <= '0; tst_q <= '0;
            ro_q   <= 1'b0; tc_q <= 1'b0;
        end else if (soft_rst) begin
            ctrl_q <= '0; cfg_q <= '0; ien_q <= '0;
            dma_q  <= '0; per_q <= '0; tst_q <= '0;
            ro_q   <= 1'b0; tc_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata;
            if ((launch_req && lz_ready) || lz_active) ctrl_q[CTL_XCH] <= 1'b1;
            if (done_evt) ctrl_q[CTL_XCH] <= 1'b0;
            if (wr_ev && idx == IDX_CFG) cfg_q <= bus_wdata;
            if (wr_ev && idx == IDX_IEN) ien_q <= bus_wdata;
            if (wr_ev && idx == IDX_DMA) dma_q <= bus_wdata;
            if (wr_ev && idx == IDX_PER) per_q <= bus_wdata;
            if (wr_ev && idx == IDX_TST) tst_q <= bus_wdata;
            if (wr_stat && bus_wdata[ST_RO]) ro_q <= 1'b0;
            if (eng_rx_push && rx_full)      ro_q <= 1'b1;
            if (wr_stat && bus_wdata[ST_TC]) tc_q <= 1'b0;
            if (done_evt)                    tc_q <= 1'b1;
        end
    end

    // status, interrupt, read mux
    logic [ST_W-1:0] stat;
    always_comb begin
        stat        = '0;
        stat[ST_TE] = tx_empty;
        stat[ST_TF] = tx_full;
        stat[ST_RR] = !rx_empty;
        stat[ST_RF] = rx_full;
        stat[ST_RO] = ro_q;
        stat[ST_TC] = tc_q;
    end

    assign irq       = |(stat & ien_q[ST_W-1:0]);
    assign burst_len = {1'b0, ctrl_q[CTL_BL_LO +: 12]} + 13'd1;

    always_comb begin
        bus_rdata = '0;
        if (rd_ev) begin
            case (idx)
                IDX_CTRL: bus_rdata = ctrl_q;
                IDX_CFG:  bus_rdata = cfg_q;
                IDX_RX:   bus_rdata = !en ? '0 : (rx_empty ? RX_EMPTY_WORD : rx_head);
                IDX_IEN:  bus_rdata = ien_q;
                IDX_STAT: bus_rdata = 32'(stat);
                IDX_DMA:  bus_rdata = dma_q;
                IDX_PER:  bus_rdata = per_q;
                IDX_TST:  bus_rdata = tst_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_empty && rx_empty && !ctrl_q[CTL_EN])); // R5
    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> ctrl_q[CTL_EN]); // R9
    AST_RX_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full && !soft_rst) |=> ro_q); // R10
    AST_XCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (lz_active && !soft_rst) |-> ctrl_q[CTL_XCH]); // R9
endmodule

// File: tb/spi_regfront_test.sv
module spi_regfront_test;
    localparam int AW = 6;
    localparam int DEP = 4;
    localparam int NC = 4;

    localparam logic [AW-1:0] A_CTRL = 6'd0,  A_CFG = 6'd4,  A_TX  = 6'd8,
                              A_RX   = 6'd12, A_IEN = 6'd16, A_ST  = 6'd20,
                              A_DMA  = 6'd24, A_PER = 6'd28, A_TST = 6'd32,
                              A_MSG  = 6'd36;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          bus_sel = 0, bus_wr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0, bus_rdata;
    logic          irq, xfer_start, eng_tx_empty;
    logic [NC-1:0] cs_n;
    logic [12:0]   burst_len;
    logic          eng_tx_pop = 0, eng_rx_push = 0, eng_done = 0;
    logic [31:0]   eng_tx_data, eng_rx_data = '0;

    int checks = 0, errors = 0;
    int txc = 0, rxc = 0;
    logic ro = 0, tc = 0;

    always #5 clk = ~clk;

    spi_regfront #(.ADDR_W(AW), .FIFO_DEPTH(DEP), .NCS(NC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .cs_n(cs_n), .xfer_start(xfer_start), .burst_len(burst_len),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_tx_empty(eng_tx_empty), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_done(eng_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        return {26'b0, tc, ro, rxc == DEP, rxc != 0, txc == DEP, txc == 0};
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rchk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic etxpop(input string req, input logic [31:0] exp);
        chk(req, eng_tx_data, exp);
        eng_tx_pop = 1;
        @(negedge clk);
        eng_tx_pop = 0;
        txc--;
    endtask

    task automatic erxpush(input logic [31:0] d);
        eng_rx_push = 1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 0;
        if (rxc == DEP) ro = 1; else rxc++;
    endtask

    task automatic edone();
        eng_done = 1;
        @(negedge clk);
        eng_done = 0;
        tc = 1;
    endtask

    task automatic expect_pulse(input string req);
        chk(req, {31'b0, xfer_start}, 32'd1);
        @(negedge clk);
        chk(req, {31'b0, xfer_start}, 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NC-1:0] cs_exp;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state (R5, R10)
        chk("R5 reset cs_n", 32'(cs_n), 32'hF);
        chk("R11 reset irq", {31'b0, irq}, 0);
        rchk("R5 reset ctrl", A_CTRL, 0);
        rchk("R10 reset status", A_ST, exp_stat());

        // R1: every unmapped or misaligned address
        for (int a = 0; a < 64; a++)
            if (a[1:0] != 0 || a / 4 >= 10) wr(AW'(a), 32'hFFFF_FFFF);
        for (int a = 0; a < 64; a++)
            if (a[1:0] != 0 || a / 4 >= 10) rchk("R1 unmapped read", AW'(a), 0);
        rchk("R1 ctrl untouched", A_CTRL, 0);
        rchk("R1 cfg untouched", A_CFG, 0);
        rchk("R1 status untouched", A_ST, exp_stat());

        // R12: storage registers
        wr(A_CFG, 32'h1357_9BDF); wr(A_DMA, 32'h0F0F_1234);
        wr(A_PER, 32'hCAFE_0001); wr(A_TST, 32'h8000_0042);
        rchk("R12 config", A_CFG, 32'h1357_9BDF);
        rchk("R12 dma", A_DMA, 32'h0F0F_1234);
        rchk("R12 period", A_PER, 32'hCAFE_0001);
        rchk("R12 test", A_TST, 32'h8000_0042);
        wr(A_IEN, 32'hA5A5_0000);
        rchk("R12 inten", A_IEN, 32'hA5A5_0000);
        wr(A_IEN, 0);

        // R2: tx write while disabled
        wr(A_TX, 32'h1111);
        rchk("R2 disabled tx dropped", A_ST, exp_stat());

        // R6: all modes x all selects, R13 burst length
        cs_exp = '1;
        for (int m = 0; m < 16; m++)
            for (int c = 0; c < 4; c++) begin
                wr(A_CTRL, 32'h1 | (32'(m) << 4) | (32'(c) << 18) | (32'(m * 4 + c) << 20));
                if (m[c]) cs_exp = ~(NC'(1) << c);
                chk("R6 chip select", 32'(cs_n), 32'(cs_exp));
                chk("R13 burst length", 32'(burst_len), 32'(m * 4 + c + 1));
                chk("R8 no start without request", {31'b0, xfer_start}, 0);
            end
        wr(A_CTRL, 32'hFFF0_0011);
        chk("R13 max burst", 32'(burst_len), 32'd4096);

        // R2: fill TX past full, drain in order
        wr(A_CTRL, 32'h11);
        for (int i = 0; i < 5; i++) begin
            wr(A_TX, 32'h1000 + 32'(i));
            if (txc < DEP) txc++;
        end
        rchk("R10 tx full status", A_ST, exp_stat());
        for (int i = 0; i < 4; i++) etxpop("R2 tx order", 32'h1000 + 32'(i));
        chk("R2 tx empty after drain", {31'b0, eng_tx_empty}, 1);

        // R8/R9: XCH start without SMC
        wr(A_CTRL, 32'h15);
        expect_pulse("R9 xch start pulse");
        rchk("R9 xch busy", A_CTRL, 32'h15);
        edone();
        rchk("R9 xch cleared", A_CTRL, 32'h11);
        rchk("R9 tc set", A_ST, exp_stat());
        wr(A_ST, 32'hFFFF_FFCF);
        rchk("R10 non-w1c bits ignored", A_ST, exp_stat());
        wr(A_ST, 32'h20); tc = 0;
        rchk("R10 tc w1c", A_ST, exp_stat());

        // R8 negative cases
        wr(A_CTRL, 32'h19);
        chk("R8 smc with empty tx", {31'b0, xfer_start}, 0);
        wr(A_CTRL, 32'h1D);
        chk("R8 xch with smc set", {31'b0, xfer_start}, 0);
        wr(A_CTRL, 32'h21);
        wr(A_CTRL, 32'h25);
        chk("R8 xch not master", {31'b0, xfer_start}, 0);
        wr(A_CTRL, 32'h11);

        // R8: SMC newly set with queued words
        wr(A_TX, 32'hAA01); wr(A_TX, 32'hAA02); txc = 2;
        chk("R7 no start smc clear", {31'b0, xfer_start}, 0);
        wr(A_CTRL, 32'h19);
        expect_pulse("R8 smc start pulse");
        edone();
        etxpop("R2 tx order smc", 32'hAA01);
        etxpop("R2 tx order smc", 32'hAA02);
        wr(A_ST, 32'h20); tc = 0;

        // R7: SMC mode tx write starts
        wr(A_TX, 32'h55); txc = 1;
        expect_pulse("R7 tx write start");
        rchk("R9 xch busy smc", A_CTRL, 32'h1D);
        edone();
        etxpop("R7 word", 32'h55);
        wr(A_ST, 32'h20); tc = 0;
        wr(A_CTRL, 32'h11);

        // R3/R10: rx fill and overflow
        for (int i = 0; i < 5; i++) erxpush(32'h2000 + 32'(i));
        rchk("R10 rx full overflow", A_ST, exp_stat());
        for (int i = 0; i < 4; i++) begin
            rchk("R3 rx order", A_RX, 32'h2000 + 32'(i));
            rxc--;
        end
        rchk("R3 rx empty word", A_RX, 32'hDEAD_BEEF);
        wr(A_ST, 32'h10); ro = 0;
        rchk("R10 ro w1c", A_ST, exp_stat());

        // R4
        wr(A_TX, 32'h7777); txc = 1;
        rchk("R4 tx reads zero", A_TX, 0);
        rchk("R4 msg reads zero", A_MSG, 0);
        wr(A_RX, 32'h1234);
        rchk("R4 rx write ignored", A_RX, 32'hDEAD_BEEF);
        wr(A_MSG, 32'h5678);
        rchk("R4 msg write ignored", A_MSG, 0);
        rchk("R4 status unchanged", A_ST, exp_stat());
        etxpop("R4 tx word", 32'h7777);

        // R11: interrupt per enable bit
        erxpush(32'h99);
        for (int b = 0; b < 6; b++) begin
            wr(A_IEN, 32'd1 << b);
            chk("R11 irq", {31'b0, irq}, 32'((exp_stat() >> b) & 1));
        end
        wr(A_IEN, 0);
        chk("R11 irq off", {31'b0, irq}, 0);

        // R5: soft reset
        wr(A_CFG, 32'hA5); wr(A_TX, 32'h4444);
        wr(A_CTRL, 0); txc = 0; rxc = 0;
        rchk("R5 cfg cleared", A_CFG, 0);
        rchk("R5 ctrl cleared", A_CTRL, 0);
        rchk("R5 fifos emptied", A_ST, exp_stat());
        chk("R5 cs released", 32'(cs_n), 32'hF);
        chk("R5 tx empty", {31'b0, eng_tx_empty}, 1);

        // R3: disabled read returns zero without popping
        erxpush(32'h77);
        rchk("R3 disabled read", A_RX, 0);
        rchk("R3 no pop when disabled", A_ST, exp_stat());
        wr(A_CTRL, 32'h1);
        rchk("R3 pop after enable", A_RX, 32'h77);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule